// File: doc/BRIEF.md
# Configurable External Interrupt Detector

This block watches a single external interrupt pin and turns qualifying activity on it into a sticky status flag and, optionally, an interrupt request. Four static configuration inputs shape it. A pin-enable gates all detection. A polarity selects either rising edges with high levels or falling edges with low levels. A mode bit chooses between edges only and edges plus levels. A request-enable decides whether the flag drives the request output or is only polled.

The pin is brought into the system clock domain through a shift-register synchronizer. An edge is seen when one synchronized sample at the inactive level is followed by one at the active level. In edge-plus-level mode the flag is re-asserted on every cycle that the synchronized pin sits at the active level, so software cannot acknowledge it until the source lets go. Software clears the flag with a one-cycle strobe. An event that arrives in the same cycle as the strobe wins, so the event is not lost.

The synchronized pin level is readable. While the system clock is stopped, a purely combinational path from the enabled pin raises a wake-up output that needs no clock edge. All control and status pins are plain levels or strobes. The block has no streaming interface, so no back-pressure rules apply.

Top module: `ext_irq_detect`

## Requirements
- R1: After reset, flag_o, irq_o and pin_level_o are 0.
- R2: When cfg_pin_en is 0, no pin activity sets flag_o.
- R3: cfg_pol = 1 detects rising edges and high levels; cfg_pol = 0 detects falling edges and low levels.
- R4: With cfg_level_mode = 0, an inactive-to-active transition of the synchronized pin sets flag_o. The flag becomes visible after the third rising clock edge following the pin change. A pin held at the active level does not set the flag again after a clear. The flag stays set until it is cleared.
- R5: With cfg_level_mode = 1, flag_o is set on every cycle that the synchronized pin is at the active level. A flag_clr during that time leaves flag_o at 1. Once the pin is inactive, a clear takes effect.
- R6: Events set flag_o regardless of cfg_irq_en. irq_o is 1 only when flag_o is 1 and cfg_irq_en is 1.
- R7: A flag_clr and a new event in the same cycle leave flag_o at 1.
- R8: pin_level_o equals the level pin_i had two rising clock edges earlier.
- R9: wake_o is 1, without any clock edge, exactly when clocks_stopped is 1, cfg_pin_en is 1 and pin_i is at the active level selected by cfg_pol.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_i | input | 1 | External interrupt pin, asynchronous |
| cfg_pin_en | input | 1 | 1 = pin acts as interrupt input |
| cfg_pol | input | 1 | 1 = rising/high, 0 = falling/low |
| cfg_level_mode | input | 1 | 1 = edges and levels, 0 = edges only |
| cfg_irq_en | input | 1 | 1 = flag drives irq_o |
| flag_clr | input | 1 | One-cycle flag clear strobe |
| clocks_stopped | input | 1 | 1 while the system clock is halted |
| flag_o | output | 1 | Sticky event flag |
| irq_o | output | 1 | Interrupt request |
| pin_level_o | output | 1 | Synchronized pin level |
| wake_o | output | 1 | Asynchronous wake-up request |

## Verification
A wrong previous-level register shows up as a flag that appears without a real transition, or one that re-triggers while the pin is held. Either shows at flag_o within three cycles of the pin change. A flag update that ranks the clear above the event loses the colliding event, and flag_o reads 0 on the very next cycle. A broken synchronizer shows on pin_level_o after two edges. Wrong polarity or gating in the wake path shows at wake_o immediately, with no clock involved.

// File: rtl/ext_irq_pkg.sv
package ext_irq_pkg;
  typedef struct packed {
    logic pin_en;
    logic pol;
    logic level_mode;
    logic irq_en;
  } irq_cfg_t;
endpackage

// File: rtl/eirq_sync.sv
module eirq_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  localparam int TOP = STAGES - 1;
  logic [TOP:0] shreg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) shreg <= '0;
    else        shreg <= {shreg[TOP-1:0], d};
  end

  assign q = shreg[TOP];
endmodule

// File: rtl/eirq_event.sv
module eirq_event
  import ext_irq_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     level,
  input  irq_cfg_t cfg,
  output logic     evt
);
  logic act;
  logic prev_act;
  logic edge_seen;

  // active-level view of the synchronized pin
  assign act = cfg.pol ? level : ~level;

  // starts "active" so no edge is inferred before an inactive sample is seen
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_act <= 1'b1;
    else        prev_act <= act;
  end

  assign edge_seen = act & ~prev_act;
  assign evt = cfg.pin_en & (edge_seen | (cfg.level_mode & act));
endmodule

// File: rtl/eirq_flag.sv
module eirq_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic evt,
  input  logic clr,
  output logic flag
);
  // an event in the clear cycle wins
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flag <= 1'b0;
    else        flag <= evt | (flag & ~clr);
  end
endmodule

// File: rtl/ext_irq_detect.sv
module ext_irq_detect
  import ext_irq_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_i,
  input  logic cfg_pin_en,
  input  logic cfg_pol,
  input  logic cfg_level_mode,
  input  logic cfg_irq_en,
  input  logic flag_clr,
  input  logic clocks_stopped,
  output logic flag_o,
  output logic irq_o,
  output logic pin_level_o,
  output logic wake_o
);
  localparam int STAGES = (SYNC_STAGES < 2) ? 2 : SYNC_STAGES;

  irq_cfg_t cfg;
  logic     sync_level;
  logic     evt;

  assign cfg = '{pin_en: cfg_pin_en, pol: cfg_pol,
                 level_mode: cfg_level_mode, irq_en: cfg_irq_en};

  eirq_sync #(.STAGES(STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(pin_i), .q(sync_level)
  );

  eirq_event u_event (
    .clk(clk), .rst_n(rst_n), .level(sync_level), .cfg(cfg), .evt(evt)
  );

  eirq_flag u_flag (
    .clk(clk), .rst_n(rst_n), .evt(evt), .clr(flag_clr), .flag(flag_o)
  );

  assign irq_o       = flag_o & cfg.irq_en;
  assign pin_level_o = sync_level;
  // clockless path for stop mode
  assign wake_o      = clocks_stopped & cfg.pin_en & ~(pin_i ^ cfg.pol);
endmodule

// File: rtl/ext_irq_checker.sv
module ext_irq_checker (
  input logic clk,
  input logic rst_n,
  input logic pin_i,
  input logic cfg_pin_en,
  input logic cfg_pol,
  input logic cfg_level_mode,
  input logic cfg_irq_en,
  input logic flag_clr,
  input logic clocks_stopped,
  input logic flag_o,
  input logic irq_o,
  input logic pin_level_o,
  input logic wake_o
);
  logic [1:0] age;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          age <= '0;
    else if (age != 2'd3) age <= age + 2'd1;
  end

  a_r2_disabled_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_pin_en && !flag_o) |=> !flag_o);

  a_r4_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_o && !flag_clr) |=> flag_o);

  a_r5_level_reasserts: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_pin_en && cfg_level_mode && (pin_level_o == cfg_pol)) |=> flag_o);

  a_r6_irq_needs_flag: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> (flag_o && cfg_irq_en));

  a_r8_sync_delay: assert property (@(posedge clk) disable iff (!rst_n)
    (age == 2'd3) |-> (pin_level_o == $past(pin_i, 2)));

  a_r9_wake_only_stopped: assert property (@(posedge clk) disable iff (!rst_n)
    wake_o |-> clocks_stopped);
endmodule

bind ext_irq_detect ext_irq_checker u_checker (
  .clk(clk), .rst_n(rst_n), .pin_i(pin_i), .cfg_pin_en(cfg_pin_en),
  .cfg_pol(cfg_pol), .cfg_level_mode(cfg_level_mode), .cfg_irq_en(cfg_irq_en),
  .flag_clr(flag_clr), .clocks_stopped(clocks_stopped), .flag_o(flag_o),
  .irq_o(irq_o), .pin_level_o(pin_level_o), .wake_o(wake_o)
);

// File: tb/ext_irq_detect_test.sv
`timescale 1ns/1ps
module ext_irq_detect_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pin_i = 1'b0;
  logic cfg_pin_en = 1'b0, cfg_pol = 1'b1, cfg_level_mode = 1'b0, cfg_irq_en = 1'b0;
  logic flag_clr = 1'b0, clocks_stopped = 1'b0;
  logic flag_o, irq_o, pin_level_o, wake_o;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  ext_irq_detect uut (
    .clk(clk), .rst_n(rst_n), .pin_i(pin_i), .cfg_pin_en(cfg_pin_en),
    .cfg_pol(cfg_pol), .cfg_level_mode(cfg_level_mode), .cfg_irq_en(cfg_irq_en),
    .flag_clr(flag_clr), .clocks_stopped(clocks_stopped), .flag_o(flag_o),
    .irq_o(irq_o), .pin_level_o(pin_level_o), .wake_o(wake_o)
  );

  // {pol, level_mode, irq_en, pin_en, expected flag, expected irq}
  localparam logic [5:0] VEC [7] = '{
    6'b1_0_1_1_1_1,  // R3 rising, R4
    6'b0_0_1_1_1_1,  // R3 falling
    6'b1_0_0_1_1_0,  // R6 polling only
    6'b1_0_1_0_0_0,  // R2 disabled
    6'b0_1_0_1_1_0,  // R5 low level, R6
    6'b0_0_1_0_0_0,  // R2 disabled, falling
    6'b1_1_1_1_1_1   // R5 high level
  };

  task automatic tick(int n = 1);
    repeat (n) begin @(posedge clk); @(negedge clk); end
  endtask

  task automatic chk(string tag, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %b expected %b", tag, act, exp);
    end
  endtask

  task automatic clear_pulse();
    flag_clr = 1'b1; tick(); flag_clr = 1'b0;
  endtask

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    tick(2);
    chk("R1 flag after reset", flag_o, 1'b0);
    chk("R1 irq after reset", irq_o, 1'b0);
    chk("R1 pin_level after reset", pin_level_o, 1'b0);
    rst_n = 1'b1;
    tick(2);

    for (int i = 0; i < 7; i++) begin
      {cfg_pol, cfg_level_mode, cfg_irq_en, cfg_pin_en} = VEC[i][5:2];
      pin_i = ~cfg_pol;
      tick(4);
      clear_pulse();
      chk($sformatf("R4 vec%0d cleared before pulse", i), flag_o, 1'b0);
      pin_i = cfg_pol;
      tick(3);
      pin_i = ~cfg_pol;
      tick(3);
      chk($sformatf("R3 vec%0d flag", i), flag_o, VEC[i][1]);
      chk($sformatf("R6 vec%0d irq", i), irq_o, VEC[i][0]);
    end

    // latency and synchronizer
    cfg_pol = 1'b1; cfg_level_mode = 1'b0; cfg_irq_en = 1'b1; cfg_pin_en = 1'b1;
    pin_i = 1'b0; tick(4); clear_pulse();
    pin_i = 1'b1; tick(2);
    chk("R4 flag not yet after two edges", flag_o, 1'b0);
    chk("R8 pin_level after two edges", pin_level_o, 1'b1);
    tick();
    chk("R4 flag after third edge", flag_o, 1'b1);

    // edge mode: held level does not re-trigger
    clear_pulse();
    chk("R4 clear while held active", flag_o, 1'b0);
    tick(3);
    chk("R4 no retrigger while held", flag_o, 1'b0);

    // level mode: clear blocked while active
    cfg_level_mode = 1'b1; tick();
    clear_pulse();
    chk("R5 clear ignored while active", flag_o, 1'b1);
    pin_i = 1'b0; tick(3);
    chk("R8 pin_level low", pin_level_o, 1'b0);
    clear_pulse();
    chk("R5 clear after release", flag_o, 1'b0);

    // clear colliding with an event
    cfg_level_mode = 1'b0;
    pin_i = 1'b1; tick(3);
    chk("R7 flag set before collision", flag_o, 1'b1);
    pin_i = 1'b0; tick(3);
    pin_i = 1'b1; tick(2);
    clear_pulse();
    chk("R7 event wins over clear", flag_o, 1'b1);
    clear_pulse();
    chk("R7 later clear works", flag_o, 1'b0);

    // asynchronous wake path
    clocks_stopped = 1'b1; pin_i = 1'b1; cfg_pol = 1'b1; cfg_pin_en = 1'b1; #1;
    chk("R9 wake active high", wake_o, 1'b1);
    cfg_pin_en = 1'b0; #1;
    chk("R9 wake gated by pin_en", wake_o, 1'b0);
    cfg_pin_en = 1'b1; pin_i = 1'b0; #1;
    chk("R9 wake off at inactive level", wake_o, 1'b0);
    cfg_pol = 1'b0; #1;
    chk("R9 wake active low", wake_o, 1'b1);
    clocks_stopped = 1'b0; #1;
    chk("R9 wake off while clocked", wake_o, 1'b0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule